// File: doc/BRIEF.md
# CPU Clock Post-Divider Bank

This block derives four slower clocks from a single fast CPU clock. The four outputs serve the ABP bus, the peripheral timers (PERIPH), the AXI fabric and the L2/DRAM path. Each output divides the CPU clock by an integer ratio from 2 to 8, and each has its own stop bit. All ratio selects and stop bits live in one 32-bit control word, written through a plain synchronous write strobe and always readable on a read port.

Software may change the ratio of an output while that output is running. The new ratio is never applied in the middle of a period. The divider finishes the period it is in, and the new ratio starts on the cycle where the output would next rise. The output therefore never shows a runt pulse.

Two outputs number their ratio codes from 1 and two number them from 0, so each output has its own decoder. A code that no ratio uses falls back to divide-by-8. Every output is a registered signal in the CPU clock domain.

Top module: `cpu_postdiv_bank`

## Requirements
- R1: After reset the control word reads 0x0000_0208. Every output is enabled and divides by 2. Every output is low while reset is asserted.
- R2: A write stores only bits [5:3], [8:6], [11:9], [14:12] and [19:16] of the write data. All other bits read back as 0. The stored value appears on the read port in the cycle after the write strobe.
- R3: Output 0 (ABP, select bits [5:3]) and output 2 (AXI, select bits [11:9]) use a code counted from 1. Codes 1 to 7 give divide-by-2 to divide-by-8, and the unused code 0 gives divide-by-8.
- R4: Output 1 (PERIPH, select bits [8:6]) and output 3 (L2 DRAM, select bits [14:12]) use a code counted from 0. Codes 0 to 6 give divide-by-2 to divide-by-8, and the unused code 7 gives divide-by-8.
- R5: For a ratio N the output is high for floor(N/2) CPU cycles and low for ceil(N/2) CPU cycles.
- R6: A change of ratio takes effect only at a period boundary, where the output would next rise. The period in progress completes at the old ratio. No high phase or low phase is ever shorter than that phase under the smaller of the old and new ratios.
- R7: The stop bit of output k is bit 16+k. While a stop bit is 1, its output is held low. Stopping takes effect only after the current period has completed, and restarting begins with a full high phase.
- R8: Each output's ratio and stop bit affect only that output. The other outputs keep toggling at their own ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast CPU clock; source of all four derived clocks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Data for the control word |
| rd_data_o | output | 32 | Current control word |
| div_clk_o | output | 4 | Derived clocks: bit 0 ABP, 1 PERIPH, 2 AXI, 3 L2 DRAM |

## Verification
Each output has a counter and a latched ratio. If either is wrong, the output shows a high or low phase of the wrong length within one period of at most eight cycles. A ratio applied at the wrong moment shows up as a shortened phase in the period right after the write. The bench sweeps all eight codes on every output and measures both phase lengths. It traces the exact sample sequence around a ratio change and around a stop. A monitor checks every completed phase on every output against the shorter of the last two programmed ratios.

// File: rtl/cpdiv_pkg.sv
package cpdiv_pkg;

   localparam int unsigned NUM_OUT  = 4;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned SEL_BASE = 3;
   localparam int unsigned OFF_BASE = 16;

   // low bit of the ratio select field of output idx
   function automatic int unsigned sel_lsb(input int unsigned idx);
      return SEL_BASE + idx * SEL_W;
   endfunction

   // stop bit of output idx
   function automatic int unsigned off_bit(input int unsigned idx);
      return OFF_BASE + idx;
   endfunction

   // outputs 0 and 2 count their ratio codes from one
   function automatic bit code_from_one(input int unsigned idx);
      return (idx == 0) || (idx == 2);
   endfunction

   function automatic logic [63:0] impl_mask();
      logic [63:0] m;
      m = '0;
      for (int unsigned k = 0; k < NUM_OUT; k++) begin
         m[sel_lsb(k) +: SEL_W] = '1;
         m[off_bit(k)]          = 1'b1;
      end
      return m;
   endfunction

   // smallest ratio on every output, all outputs running
   function automatic logic [63:0] reset_word();
      logic [63:0] m;
      m = '0;
      for (int unsigned k = 0; k < NUM_OUT; k++)
         if (code_from_one(k)) m[sel_lsb(k)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cpdiv_ctrl_reg.sv
module cpdiv_ctrl_reg #(
   parameter int unsigned       DATA_W     = 32,
   parameter logic [DATA_W-1:0] KEEP_MASK  = '1,
   parameter logic [DATA_W-1:0] RESET_WORD = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] ctrl_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctrl_o <= RESET_WORD & KEEP_MASK;
      else if (wr_en_i) ctrl_o <= wr_data_i & KEEP_MASK;
   end

   assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_o & ~KEEP_MASK) == '0);

   assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> ctrl_o == ($past(wr_data_i) & KEEP_MASK));

endmodule

// File: rtl/cpdiv_sel_decode.sv
module cpdiv_sel_decode #(
   parameter int unsigned SEL_W         = 3,
   parameter int unsigned RAT_W         = 4,
   parameter int unsigned MIN_DIV       = 2,
   parameter int unsigned MAX_DIV       = 8,
   parameter bit          CODE_FROM_ONE = 1'b1
) (
   input  logic [SEL_W-1:0] code_i,
   output logic [RAT_W-1:0] ratio_o
);

   localparam int unsigned SPAN = MAX_DIV - MIN_DIV;

   generate
      if (CODE_FROM_ONE) begin : g_from_one
         always_comb begin
            if (code_i == '0 || 32'(code_i) > SPAN + 1)
               ratio_o = RAT_W'(MAX_DIV);
            else
               ratio_o = RAT_W'(code_i) + RAT_W'(MIN_DIV - 1);
         end
      end else begin : g_from_zero
         always_comb begin
            if (32'(code_i) > SPAN)
               ratio_o = RAT_W'(MAX_DIV);
            else
               ratio_o = RAT_W'(code_i) + RAT_W'(MIN_DIV);
         end
      end
   endgenerate

endmodule

// File: rtl/cpdiv_divider.sv
module cpdiv_divider #(
   parameter int unsigned RAT_W   = 4,
   parameter int unsigned MIN_DIV = 2,
   parameter int unsigned MAX_DIV = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [RAT_W-1:0] ratio_i,
   input  logic             en_i,
   output logic             clk_o
);

   logic [RAT_W-1:0] cnt_q, cnt_d;
   logic [RAT_W-1:0] ratio_q, ratio_d;
   logic             run_q, run_d;
   logic             out_d;
   logic             at_end;

   // ratio and run state are only reloaded on the last cycle of a period
   always_comb begin
      at_end  = (cnt_q == ratio_q - RAT_W'(1));
      cnt_d   = at_end ? '0      : cnt_q + RAT_W'(1);
      ratio_d = at_end ? ratio_i : ratio_q;
      run_d   = at_end ? en_i    : run_q;
      out_d   = run_d && (cnt_d < (ratio_d >> 1));
   end

   // reset parks the counter on a boundary so the first edge loads the register
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= RAT_W'(MIN_DIV - 1);
         ratio_q <= RAT_W'(MIN_DIV);
         run_q   <= 1'b0;
         clk_o   <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         ratio_q <= ratio_d;
         run_q   <= run_d;
         clk_o   <= out_d;
      end
   end

   assert_cnt_below_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < ratio_q);

   assert_new_ratio_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      at_end |-> (ratio_i >= RAT_W'(MIN_DIV)) && (ratio_i <= RAT_W'(MAX_DIV)));

   assert_rise_on_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_o) |-> cnt_q == '0);

   assert_ratio_moves_on_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ratio_q != $past(ratio_q)) |-> cnt_q == '0);

   assert_stopped_is_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> !clk_o);

endmodule

// File: rtl/cpu_postdiv_bank.sv
module cpu_postdiv_bank #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned MIN_DIV = 2,
   parameter int unsigned MAX_DIV = 8
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          wr_en_i,
   input  logic [DATA_W-1:0]             wr_data_i,
   output logic [DATA_W-1:0]             rd_data_o,
   output logic [cpdiv_pkg::NUM_OUT-1:0] div_clk_o
);

   import cpdiv_pkg::*;

   localparam int unsigned RAT_W = $clog2(MAX_DIV + 1);
   localparam logic [DATA_W-1:0] KEEP  = DATA_W'(impl_mask());
   localparam logic [DATA_W-1:0] RST_W = DATA_W'(reset_word());

   generate
      if (DATA_W < OFF_BASE + NUM_OUT) begin : g_bad_width
         $error("control word too narrow for the stop bits");
      end
      if (MAX_DIV - MIN_DIV + 1 > (1 << SEL_W) - 1) begin : g_bad_span
         $error("ratio range does not fit the select field");
      end
      if (MIN_DIV < 2 || MAX_DIV < MIN_DIV) begin : g_bad_div
         $error("illegal divide range");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;

   cpdiv_ctrl_reg #(
      .DATA_W    (DATA_W),
      .KEEP_MASK (KEEP),
      .RESET_WORD(RST_W)
   ) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_data_i(wr_data_i),
      .ctrl_o   (ctrl_q)
   );

   assign rd_data_o = ctrl_q;

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
      localparam int unsigned LSB = sel_lsb(i);
      localparam int unsigned OFF = off_bit(i);
      localparam bit          ONE = code_from_one(i);

      logic [RAT_W-1:0] ratio;

      cpdiv_sel_decode #(
         .SEL_W        (SEL_W),
         .RAT_W        (RAT_W),
         .MIN_DIV      (MIN_DIV),
         .MAX_DIV      (MAX_DIV),
         .CODE_FROM_ONE(ONE)
      ) u_dec (
         .code_i (ctrl_q[LSB +: SEL_W]),
         .ratio_o(ratio)
      );

      cpdiv_divider #(
         .RAT_W  (RAT_W),
         .MIN_DIV(MIN_DIV),
         .MAX_DIV(MAX_DIV)
      ) u_div (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .ratio_i(ratio),
         .en_i   (!ctrl_q[OFF]),
         .clk_o  (div_clk_o[i])
      );
   end

endmodule

// File: tb/cpu_postdiv_bank_bench.sv
module cpu_postdiv_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NOUT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  dclk;

   int total = 0;
   int bad = 0;
   logic [31:0] shadow = 32'h0000_0208;
   int cur_n [NOUT];
   int prev_n [NOUT];
   bit mon_on = 1'b0;

   cpu_postdiv_bank u_cpu_postdiv_bank (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_en_i  (wr_en),
      .wr_data_i(wr_data),
      .rd_data_o(rd_data),
      .div_clk_o(dclk)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R3 / R4 encodings
   function automatic int ratio_of(input int o, input int c);
      if (o == 0 || o == 2) return (c == 0) ? 8 : c + 1;
      return (c == 7) ? 8 : c + 2;
   endfunction

   function automatic void note_word(input logic [31:0] d);
      shadow = d;
      for (int o = 0; o < NOUT; o++) begin
         prev_n[o] = cur_n[o];
         cur_n[o]  = ratio_of(o, int'(d[3 + 3 * o +: 3]));
      end
   endfunction

   task automatic write_reg(input logic [31:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      note_word(d);
      repeat (10) @(negedge clk);
   endtask

   task automatic set_code(input int o, input int c);
      logic [31:0] d;
      d = shadow;
      d[3 + 3 * o +: 3] = 3'(c);
      write_reg(d);
   endtask

   task automatic wait_rise(input int o);
      int g;
      logic p;
      g = 0;
      p = dclk[o];
      @(negedge clk);
      while (!(p == 1'b0 && dclk[o] == 1'b1) && g < 100) begin
         p = dclk[o];
         @(negedge clk);
         g++;
      end
   endtask

   task automatic measure(input int o, output int h, output int l);
      wait_rise(o);
      h = 0;
      while (dclk[o] == 1'b1 && h < 20) begin h++; @(negedge clk); end
      l = 0;
      while (dclk[o] == 1'b0 && l < 40) begin l++; @(negedge clk); end
   endtask

   // phase monitor: R6 lower bound against the last two programmed ratios
   int  run_len [NOUT];
   logic last_v [NOUT];
   bit  seen [NOUT];
   always @(negedge clk) begin
      if (mon_on) begin
         for (int o = 0; o < NOUT; o++) begin
            if (dclk[o] !== last_v[o]) begin
               if (seen[o]) begin
                  int mn;
                  mn = (prev_n[o] < cur_n[o]) ? prev_n[o] : cur_n[o];
                  if (last_v[o] == 1'b1)
                     chk(run_len[o] >= mn / 2 && run_len[o] <= 4, "R6 high phase", run_len[o], mn / 2);
                  else
                     chk(run_len[o] >= mn - mn / 2, "R6 low phase", run_len[o], mn - mn / 2);
               end
               seen[o]    = 1'b1;
               run_len[o] = 1;
               last_v[o]  = dclk[o];
            end else begin
               run_len[o]++;
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int h, l, n;
      logic [11:0] tr;
      for (int o = 0; o < NOUT; o++) begin
         cur_n[o] = 2; prev_n[o] = 2; run_len[o] = 0; last_v[o] = 1'b0; seen[o] = 1'b0;
      end

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(rd_data == 32'h0000_0208, "R1 reset word", int'(rd_data), 32'h208);
      chk(dclk == 4'b0000, "R1 low in reset", int'(dclk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      chk(rd_data == 32'h0000_0208, "R1 word after reset", int'(rd_data), 32'h208);
      for (int o = 0; o < NOUT; o++) begin
         measure(o, h, l);
         chk(h == 1 && l == 1, "R1 divide by 2", h * 10 + l, 11);
      end

      // R2 storage mask
      write_reg(32'hFFFF_FFFF);
      chk(rd_data == 32'h000F_7FF8, "R2 all ones", int'(rd_data), 32'h000F7FF8);
      write_reg(32'h0000_0000);
      chk(rd_data == 32'h0000_0000, "R2 all zeros", int'(rd_data), 0);
      write_reg(32'hA5A5_5A5A);
      chk(rd_data == (32'hA5A5_5A5A & 32'h000F_7FF8), "R2 pattern", int'(rd_data),
          int'(32'hA5A5_5A5A & 32'h000F_7FF8));
      write_reg(32'h0000_0208);

      // R3 / R4 / R5 sweep over every code of every output
      for (int o = 0; o < NOUT; o++) begin
         for (int c = 0; c < 8; c++) begin
            set_code(o, c);
            n = ratio_of(o, c);
            measure(o, h, l);
            chk(h == n / 2, (o == 0 || o == 2) ? "R3 high length" : "R4 high length", h, n / 2);
            chk(l == n - n / 2, "R5 low length", l, n - n / 2);
         end
      end

      // R8 mixed ratios on all outputs at once
      set_code(0, 3); set_code(1, 1); set_code(2, 5); set_code(3, 5);
      for (int o = 0; o < NOUT; o++) begin
         n = ratio_of(o, int'(shadow[3 + 3 * o +: 3]));
         measure(o, h, l);
         chk(h == n / 2 && l == n - n / 2, "R8 independent ratio", h * 10 + l, (n / 2) * 10 + n - n / 2);
      end

      // R6 divide-by-8 to divide-by-2 at the boundary
      set_code(0, 7);
      wait_rise(0);
      for (int i = 0; i < 12; i++) begin
         tr[11 - i] = dclk[0];
         if (i == 0) begin
            wr_en = 1'b1;
            wr_data = (shadow & ~32'h38) | 32'h08;
         end else if (i == 1) begin
            wr_en = 1'b0;
            note_word(wr_data);
         end
         @(negedge clk);
      end
      chk(tr == 12'b1111_0000_1010, "R6 8 to 2 trace", int'(tr), 12'hF0A);
      repeat (10) @(negedge clk);

      // R6 divide-by-2 to divide-by-7
      wait_rise(0);
      for (int i = 0; i < 10; i++) begin
         tr[11 - i] = dclk[0];
         if (i == 0) begin
            wr_en = 1'b1;
            wr_data = (shadow & ~32'h38) | 32'h30;
         end else if (i == 1) begin
            wr_en = 1'b0;
            note_word(wr_data);
         end
         @(negedge clk);
      end
      chk(tr[11:2] == 10'b10_1110_0001, "R6 2 to 7 trace", int'(tr[11:2]), 10'h2E1);
      repeat (10) @(negedge clk);

      // R7 stop at the period boundary (PERIPH divide-by-4, code 2)
      set_code(1, 2);
      wait_rise(1);
      for (int i = 0; i < 12; i++) begin
         tr[11 - i] = dclk[1];
         if (i == 0) begin
            wr_en = 1'b1;
            wr_data = shadow | 32'h0002_0000;
         end else if (i == 1) begin
            wr_en = 1'b0;
            note_word(wr_data);
         end
         @(negedge clk);
      end
      chk(tr == 12'b1100_0000_0000, "R7 stop trace", int'(tr), 12'hC00);
      begin
         int highs, rises;
         logic p0;
         highs = 0; rises = 0; p0 = dclk[0];
         for (int i = 0; i < 24; i++) begin
            if (dclk[1]) highs++;
            if (!p0 && dclk[0]) rises++;
            p0 = dclk[0];
            @(negedge clk);
         end
         chk(highs == 0, "R7 held low", highs, 0);
         chk(rises >= 3, "R8 neighbour runs", rises, 3);
      end
      write_reg(shadow & ~32'h0002_0000);
      measure(1, h, l);
      chk(h == 2 && l == 2, "R7 restart full phases", h * 10 + l, 22);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule